// File: doc/BRIEF.md
# Lowest Enabled State Finder

This block scans a vector of per-state enable flags and reports the position of the lowest-numbered flag that is set. A flag of 1 means the state is still enabled; a flag of 0 means it has been purged. It is used as the starting point for survivor traceback or decoded-bit output whenever the index of the truly optimal state is not available, so some live state has to be chosen by a cheap, fixed rule.

The search is not a single wide priority encoder. The flags are folded into an OR tree. A small radix-4 priority encoder then works at each level, from the coarsest level to the finest. The coarse encoder picks the lowest non-empty group of 16 and gives the top index field. A multiplexer picks the four subgroup ORs of that group from the tree, and they feed the middle encoder. A last multiplexer picks four raw flags for the bottom encoder. The index and a valid bit are registered at the output.

Top module: `lowest_state_finder`

## Requirements
- R1: The outputs reflect the flags sampled at the previous rising edge of clk_i. A change on flags_i does not alter idx_o or valid_o before the next rising edge.
- R2: valid_o is 1 exactly when at least one bit of the sampled flags is 1.
- R3: When valid_o is 1, idx_o equals the bit position of the lowest set flag, where flags_i bit 0 is state 0.
- R4: Set flags at positions above the lowest set flag have no effect on idx_o.
- R5: When every flag is 0, valid_o is 0 and idx_o is 0.
- R6: While rst_ni is low, idx_o and valid_o are 0 at once, independent of clk_i.
- R7: Results are correct across group boundaries. idx_o[5:4] gives the 16-flag group, idx_o[3:2] the 4-flag subgroup within it, and idx_o[1:0] the flag within that subgroup. This holds for lowest flags at 15, 16, 63 and similar edges.
- R8: A single set flag at any position from 0 to 63 yields that position on idx_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 64 | Per-state enable flags, 1 = enabled |
| idx_o | output | 6 | Index of lowest enabled state, registered |
| valid_o | output | 1 | At least one flag was set, registered |

## Verification
The bench builds the block with its default parameters: radix 4 and three levels, which gives 64 flags and a 6-bit index. At this size every flag position can be swept one at a time. Each encoder level, each multiplexer selection and every group edge at 16-flag and 4-flag spacing is reached by single-flag patterns. Patterns that add higher set flags check that only the lowest one counts.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  parameter int unsigned LSF_RADIX  = 4;
  parameter int unsigned LSF_LEVELS = 3;
endpackage

// File: rtl/lsf_prio_leaf.sv
module lsf_prio_leaf #(
  parameter int unsigned RADIX = 4,
  parameter int unsigned RAD_W = $clog2(RADIX)
) (
  input  logic [RADIX-1:0] req_i,
  output logic [RAD_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = RADIX - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = RAD_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/lsf_or_tree.sv
module lsf_or_tree #(
  parameter int unsigned RADIX  = 4,
  parameter int unsigned LEVELS = 3,
  localparam int unsigned FLAG_W = RADIX ** LEVELS
) (
  input  logic [FLAG_W-1:0]             flags_i,
  output logic [LEVELS-1:0][FLAG_W-1:0] tree_o
);
  // row LEVELS-1 holds raw flags; row d holds RADIX**(d+1) group ORs
  assign tree_o[LEVELS-1] = flags_i;

  for (genvar d = 0; d < LEVELS - 1; d++) begin : g_row
    localparam int unsigned NODES = RADIX ** (d + 1);
    for (genvar j = 0; j < NODES; j++) begin : g_node
      assign tree_o[d][j] = |tree_o[d+1][j*RADIX +: RADIX];
    end
    assign tree_o[d][FLAG_W-1:NODES] = '0;
  end
endmodule

// File: rtl/lowest_state_finder.sv
module lowest_state_finder
  import lsf_pkg::*;
#(
  parameter int unsigned RADIX  = LSF_RADIX,
  parameter int unsigned LEVELS = LSF_LEVELS,
  localparam int unsigned RAD_W  = $clog2(RADIX),
  localparam int unsigned FLAG_W = RADIX ** LEVELS,
  localparam int unsigned IDX_W  = RAD_W * LEVELS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);
  logic [LEVELS-1:0][FLAG_W-1:0] or_tree;
  logic [LEVELS-1:0][RAD_W-1:0]  lvl_idx;
  logic [LEVELS-1:0]             lvl_any;
  logic [LEVELS:0][IDX_W-1:0]    pfx;
  logic                          found;
  logic [IDX_W-1:0]              idx_q;
  logic                          valid_q;

  lsf_or_tree #(.RADIX(RADIX), .LEVELS(LEVELS)) u_or_tree (
    .flags_i (flags_i),
    .tree_o  (or_tree)
  );

  assign pfx[0] = '0;

  // each stage picks RADIX nodes of its tree row under the prefix chosen so far
  for (genvar d = 0; d < LEVELS; d++) begin : g_stage
    logic [RADIX-1:0] grp;
    assign grp = RADIX'(or_tree[d] >> (pfx[d] << RAD_W));

    lsf_prio_leaf #(.RADIX(RADIX), .RAD_W(RAD_W)) u_leaf (
      .req_i (grp),
      .idx_o (lvl_idx[d]),
      .any_o (lvl_any[d])
    );

    assign pfx[d+1] = (pfx[d] << RAD_W) | IDX_W'(lvl_idx[d]);
  end

  // deeper stages are non-empty whenever the top one is
  assign found = &lvl_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= found ? pfx[LEVELS] : '0;
      valid_q <= found;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;

  // one registered sample must exist before history-based checks apply
  logic chk_arm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_arm <= 1'b0;
    else         chk_arm <= 1'b1;
  end

  a_r2_valid_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_arm |-> (valid_o == (|$past(flags_i))));

  a_r5_empty_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (idx_o == '0));

  a_r3_points_at_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_arm && valid_o) |-> ((($past(flags_i) >> idx_o) & FLAG_W'(1)) != '0));

  a_r4_none_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_arm && valid_o) |-> (($past(flags_i) & ((FLAG_W'(1) << idx_o) - FLAG_W'(1))) == '0));
endmodule

// File: tb/lowest_state_finder_bench.sv
module lowest_state_finder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  localparam logic [63:0] VEC_FLAGS [NVEC] = '{
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
    64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE,
    64'h0000_0000_0000_0000, 64'h00F0_0000_0000_0000,
    64'h0000_0000_0000_1100, 64'h8000_0000_0000_0008,
    64'h0000_0010_0000_0000, 64'hA000_0000_0000_0000
  };
  localparam logic [5:0] VEC_IDX [NVEC] = '{
    6'd0, 6'd63, 6'd16, 6'd15, 6'd0, 6'd1, 6'd0, 6'd52, 6'd8, 6'd3, 6'd36, 6'd61
  };
  localparam logic VEC_VLD [NVEC] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] flags = '0;
  logic [5:0]  idx;
  logic        valid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowest_state_finder u_lowest_state_finder (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .flags_i (flags),
    .idx_o   (idx),
    .valid_o (valid)
  );

  task automatic check(input logic [5:0] e_idx, input logic e_vld, input string req);
    n_chk++;
    if (idx !== e_idx || valid !== e_vld) begin
      n_bad++;
      $display("FAIL %s: idx=%0d valid=%0b expected idx=%0d valid=%0b",
               req, idx, valid, e_idx, e_vld);
    end
  endtask

  // drive on falling edge, result appears after the next rising edge
  task automatic apply(input logic [63:0] f);
    @(negedge clk);
    flags = f;
    @(negedge clk);
  endtask

  initial begin
    // R6: reset state with nonzero flags present
    flags = 64'h10;
    repeat (3) @(negedge clk);
    check(6'd0, 1'b0, "R6 reset");
    rst_n = 1'b1;

    // table walk: R3 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC_FLAGS[i]);
      check(VEC_IDX[i], VEC_VLD[i], "R3/R5/R7 table");
    end

    // R5 / R2: all clear after busy pattern
    apply(64'hFFFF_0000_0000_0000);
    check(6'd48, 1'b1, "R2 busy");
    apply(64'h0);
    check(6'd0, 1'b0, "R5 empty");

    // R8: single flag sweep
    for (int p = 0; p < 64; p++) begin
      apply(64'h1 << p);
      check(6'(p), 1'b1, "R8 single");
    end

    // R4: every flag above the lowest also set
    for (int p = 0; p < 64; p += 5) begin
      apply(~64'h0 << p);
      check(6'(p), 1'b1, "R4 upper ignored");
    end

    // R1: output holds until next rising edge
    apply(64'h0000_0000_0040_0000);
    check(6'd22, 1'b1, "R1 first");
    flags = 64'h2;
    #1;
    check(6'd22, 1'b1, "R1 hold");
    @(negedge clk);
    check(6'd1, 1'b1, "R1 update");

    // R6: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check(6'd0, 1'b0, "R6 async");
    @(negedge clk);
    rst_n = 1'b1;
    apply(64'h0000_8000_0000_0000);
    check(6'd47, 1'b1, "R7 after reset");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule